// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command bus of a single-rank, four-bank SDR SDRAM from the end of reset until the memory is ready. It starts with a long idle interval in which only NOP commands appear. During that interval CKE and the byte masks stay high, so the data pins remain high-impedance. It then issues a precharge to all banks. The last two steps are a mode register load and a burst of auto-refresh commands. A parameter sets which of the two comes first.

Every delay is given in nanoseconds and converted to clocks by rounding up. The conversion uses a clock-period parameter in picoseconds, so one netlist can target a different clock or speed grade by changing parameters only. After the final spacing has expired, the block raises a ready flag and releases the byte masks. From then on it drives only NOPs, until a memory controller takes over the bus.

Top module: `sdram_boot_seq`

## Requirements
- R1: Let N_WAIT = ceil(T_WAIT_NS*1000/CLK_PS). After reset is released, the bus shows only NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) on each of the first N_WAIT-1 rising edges. The first other command appears on the N_WAIT-th edge.
- R2: cke is high at all times. dqm is all ones from reset until init_done rises, and all zeros from then on.
- R3: The first command is precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0) with address bit 10 high, all other address bits zero and bank select zero.
- R4: The mode register load (all four command lines low) drives bank select zero and an address word built from these fields:
  - bits 2:0 hold the burst-length code;
  - bit 3 holds the interleaved-order flag;
  - bits 6:4 hold the CAS latency;
  - bit 9 holds the single-write flag;
  - every other bit is zero.
- R5: Exactly REF_COUNT auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) are issued, each with address and bank select zero.
- R6: With MODE_FIRST=0 the order is precharge, all refreshes, then mode load. With MODE_FIRST=1 it is precharge, mode load, then all refreshes.
- R7: Each command is one cycle wide. The number of cycles from a command to the next command, or to the rise of init_done, equals the rounded-up clock count of the spacing for that command: T_RP_NS after a precharge, T_RFC_NS after a refresh, T_MRD_NS after a mode load.
- R8: init_done rises on the edge on which the last spacing expires. It then stays high until reset, and only NOPs follow.
- R9: A synchronous active-high reset returns the bus to NOP, cke high, dqm all ones and init_done low. After release, the whole sequence restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | DQM_W | Byte-lane masks |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank select |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The bench builds two instances side by side.

The first keeps the defaults: an 8000 ps period, the full 200 us idle, the faster grade's spacings and refresh before the mode load. At these values 16 ns divides evenly into 2 clocks while 20 ns and 68 ns round up to 3 and 9.

The second uses a 7500 ps period, a 2 us idle, the slower grade's spacings, nine refreshes, mode-load-first ordering and non-default mode fields. At these values every spacing has a fraction to round up (267, 4, 12 and 3 clocks).

Both instances are run through two complete sequences, with a mid-life reset between them, so that both orderings, exact and fractional rounding, and the restart are covered.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    // Command encoding on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE_WAIT,
        ST_AFTER_PRE,
        ST_AFTER_REF,
        ST_AFTER_MRS,
        ST_READY
    } boot_state_e;

    typedef struct packed {
        sdram_cmd_e cmd;
        logic       finish;
    } boot_step_t;

    // Nanoseconds to whole clocks, rounding any fraction up, at least one clock.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ps);
        longint num;
        longint c;
        num = longint'(t_ns) * 1000;
        c   = (num + longint'(clk_ps) - 1) / longint'(clk_ps);
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Mode word: the bit positions are decoded by the memory device.
    function automatic logic [11:0] mode_word(input int bl_code, input int interleave,
                                              input int cas_lat, input int single_wr);
        logic [11:0] w;
        w      = '0;
        w[2:0] = bl_code[2:0];
        w[3]   = interleave[0];
        w[6:4] = cas_lat[2:0];
        w[9]   = single_wr[0];
        return w;
    endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer
    import sdram_boot_pkg::*;
#(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= W'(RST_VAL);
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
    import sdram_boot_pkg::*;
#(
    parameter int TMR_W      = 16,
    parameter int REF_COUNT  = 8,
    parameter int MODE_FIRST = 0,
    parameter int N_RP       = 3,
    parameter int N_RFC      = 9,
    parameter int N_MRD      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             expired,
    output logic             load,
    output logic [TMR_W-1:0] load_val,
    output boot_step_t       step
);

    localparam int RC_W = $clog2(REF_COUNT + 1);
    localparam logic [TMR_W-1:0] GAP_RP  = TMR_W'(N_RP - 1);
    localparam logic [TMR_W-1:0] GAP_RFC = TMR_W'(N_RFC - 1);
    localparam logic [TMR_W-1:0] GAP_MRD = TMR_W'(N_MRD - 1);
    localparam logic [RC_W-1:0]  REF_LAST = RC_W'(REF_COUNT);

    boot_state_e     state, state_n;
    logic [RC_W-1:0] refs, refs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE_WAIT;
            refs  <= '0;
        end else begin
            state <= state_n;
            refs  <= refs_n;
        end
    end

    always_comb begin
        state_n     = state;
        refs_n      = refs;
        step.cmd    = CMD_NOP;
        step.finish = 1'b0;
        load        = 1'b0;
        load_val    = '0;
        if (expired) begin
            unique case (state)
                ST_IDLE_WAIT: begin
                    step.cmd = CMD_PRE;
                    load     = 1'b1;
                    load_val = GAP_RP;
                    state_n  = ST_AFTER_PRE;
                end
                ST_AFTER_PRE: begin
                    load = 1'b1;
                    if (MODE_FIRST != 0) begin
                        step.cmd = CMD_MRS;
                        load_val = GAP_MRD;
                        state_n  = ST_AFTER_MRS;
                    end else begin
                        step.cmd = CMD_REF;
                        load_val = GAP_RFC;
                        refs_n   = RC_W'(1);
                        state_n  = ST_AFTER_REF;
                    end
                end
                ST_AFTER_REF: begin
                    if (refs < REF_LAST) begin
                        step.cmd = CMD_REF;
                        load     = 1'b1;
                        load_val = GAP_RFC;
                        refs_n   = refs + 1'b1;
                    end else if (MODE_FIRST != 0) begin
                        step.finish = 1'b1;
                        state_n     = ST_READY;
                    end else begin
                        step.cmd = CMD_MRS;
                        load     = 1'b1;
                        load_val = GAP_MRD;
                        state_n  = ST_AFTER_MRS;
                    end
                end
                ST_AFTER_MRS: begin
                    if (MODE_FIRST != 0) begin
                        step.cmd = CMD_REF;
                        load     = 1'b1;
                        load_val = GAP_RFC;
                        refs_n   = RC_W'(1);
                        state_n  = ST_AFTER_REF;
                    end else begin
                        step.finish = 1'b1;
                        state_n     = ST_READY;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdram_boot_drive.sv
module sdram_boot_drive
    import sdram_boot_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                BA_W      = 2,
    parameter int                DQM_W     = 8,
    parameter logic [ADDR_W-1:0] MODE_BITS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  boot_step_t        step,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);

    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    sdram_cmd_e cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_NOP;
            addr  <= '0;
            done  <= 1'b0;
            dqm   <= '1;
        end else begin
            cmd_q <= step.cmd;
            unique case (step.cmd)
                CMD_PRE: addr <= ALL_BANKS;
                CMD_MRS: addr <= MODE_BITS;
                default: addr <= '0;
            endcase
            done <= done | step.finish;
            dqm  <= (done | step.finish) ? '0 : '1;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign cke = 1'b1;
    assign ba  = '0;

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int CLK_PS       = 8000,
    parameter int T_WAIT_NS    = 200000,
    parameter int T_RP_NS      = 20,
    parameter int T_RFC_NS     = 68,
    parameter int T_MRD_NS     = 16,
    parameter int REF_COUNT    = 8,
    parameter int MODE_FIRST   = 0,
    parameter int BURST_CODE   = 3,
    parameter int INTERLEAVE   = 0,
    parameter int CAS_LAT      = 3,
    parameter int SINGLE_WRITE = 0,
    parameter int ADDR_W       = 12,
    parameter int BA_W         = 2,
    parameter int DQM_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    localparam int N_WAIT = ns_to_cycles(T_WAIT_NS, CLK_PS);
    localparam int N_RP   = ns_to_cycles(T_RP_NS, CLK_PS);
    localparam int N_RFC  = ns_to_cycles(T_RFC_NS, CLK_PS);
    localparam int N_MRD  = ns_to_cycles(T_MRD_NS, CLK_PS);
    localparam int N_MAX  = max_of4(N_WAIT, N_RP, N_RFC, N_MRD);
    localparam int TMR_W  = $clog2(N_MAX + 1);
    localparam logic [ADDR_W-1:0] MODE_BITS =
        ADDR_W'(mode_word(BURST_CODE, INTERLEAVE, CAS_LAT, SINGLE_WRITE));

    logic             expired;
    logic             load;
    logic [TMR_W-1:0] load_val;
    boot_step_t       step;

    sdram_boot_timer #(
        .W       (TMR_W),
        .RST_VAL (N_WAIT - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sdram_boot_fsm #(
        .TMR_W      (TMR_W),
        .REF_COUNT  (REF_COUNT),
        .MODE_FIRST (MODE_FIRST),
        .N_RP       (N_RP),
        .N_RFC      (N_RFC),
        .N_MRD      (N_MRD)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .step     (step)
    );

    sdram_boot_drive #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .DQM_W     (DQM_W),
        .MODE_BITS (MODE_BITS)
    ) u_drive (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .dqm   (dqm),
        .addr  (addr),
        .ba    (ba),
        .done  (init_done)
    );

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk
    import sdram_boot_pkg::*;
#(
    parameter int CLK_PS       = 8000,
    parameter int T_WAIT_NS    = 200000,
    parameter int T_RP_NS      = 20,
    parameter int T_RFC_NS     = 68,
    parameter int T_MRD_NS     = 16,
    parameter int REF_COUNT    = 8,
    parameter int BURST_CODE   = 3,
    parameter int INTERLEAVE   = 0,
    parameter int CAS_LAT      = 3,
    parameter int SINGLE_WRITE = 0,
    parameter int ADDR_W       = 12,
    parameter int BA_W         = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done
);

    localparam int C_WAIT = ns_to_cycles(T_WAIT_NS, CLK_PS);
    localparam int C_RP   = ns_to_cycles(T_RP_NS, CLK_PS);
    localparam int C_RFC  = ns_to_cycles(T_RFC_NS, CLK_PS);
    localparam int C_MRD  = ns_to_cycles(T_MRD_NS, CLK_PS);
    localparam logic [ADDR_W-1:0] EXP_MODE =
        ADDR_W'(mode_word(BURST_CODE, INTERLEAVE, CAS_LAT, SINGLE_WRITE));

    logic [3:0] bus;
    logic       is_cmd;
    int         since_rst;
    int         since_cmd;
    int         need;
    int         ref_seen;
    logic       seen_any;

    assign bus    = {cs_n, ras_n, cas_n, we_n};
    assign is_cmd = (bus != CMD_NOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
            since_cmd <= 0;
            need      <= 0;
            ref_seen  <= 0;
            seen_any  <= 1'b0;
        end else begin
            since_rst <= since_rst + 1;
            if (is_cmd) begin
                since_cmd <= 1;
                seen_any  <= 1'b1;
                if (bus == CMD_PRE)      need <= C_RP;
                else if (bus == CMD_REF) need <= C_RFC;
                else                     need <= C_MRD;
                if (bus == CMD_REF) ref_seen <= ref_seen + 1;
            end else begin
                since_cmd <= since_cmd + 1;
            end
        end
    end

    assert_idle_wait_R1: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && !seen_any) |-> (since_rst >= C_WAIT));

    assert_first_is_pre_R3: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && !seen_any) |-> (bus == CMD_PRE));

    assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (rst)
        (bus == CMD_PRE) |-> (addr[10] && ba == '0));

    assert_mode_word_R4: assert property (@(posedge clk) disable iff (rst)
        (bus == CMD_MRS) |-> (addr == EXP_MODE && ba == '0));

    assert_ref_total_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (ref_seen == REF_COUNT));

    assert_min_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && seen_any) |-> (since_cmd >= need));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (bus == CMD_NOP));

endmodule

bind sdram_boot_seq sdram_boot_chk #(
    .CLK_PS       (CLK_PS),
    .T_WAIT_NS    (T_WAIT_NS),
    .T_RP_NS      (T_RP_NS),
    .T_RFC_NS     (T_RFC_NS),
    .T_MRD_NS     (T_MRD_NS),
    .REF_COUNT    (REF_COUNT),
    .BURST_CODE   (BURST_CODE),
    .INTERLEAVE   (INTERLEAVE),
    .CAS_LAT      (CAS_LAT),
    .SINGLE_WRITE (SINGLE_WRITE),
    .ADDR_W       (ADDR_W),
    .BA_W         (BA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done)
);

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    function automatic int up_div(input int ns, input int ps);
        longint v;
        v = (longint'(ns) * 1000 + longint'(ps) - 1) / longint'(ps);
        return (v < 1) ? 1 : int'(v);
    endfunction

    // Instance A: defaults
    localparam int A_NW = up_div(200000, 8000);
    localparam int A_RP = up_div(20, 8000);
    localparam int A_RF = up_div(68, 8000);
    localparam int A_MR = up_div(16, 8000);
    localparam int A_NR = 8;
    localparam bit A_MF = 1'b0;
    localparam logic [11:0] A_MW = {2'b00, 1'b0, 2'b00, 3'd3, 1'b0, 3'd3};
    // Instance B: slower grade, mode load first
    localparam int B_NW = up_div(2000, 7500);
    localparam int B_RP = up_div(24, 7500);
    localparam int B_RF = up_div(84, 7500);
    localparam int B_MR = up_div(20, 7500);
    localparam int B_NR = 9;
    localparam bit B_MF = 1'b1;
    localparam logic [11:0] B_MW = {2'b00, 1'b1, 2'b00, 3'd2, 1'b1, 3'd2};

    logic [3:0]  a_cmd, b_cmd;
    logic        a_cke, b_cke, a_done, b_done;
    logic [7:0]  a_dqm, b_dqm;
    logic [11:0] a_addr, b_addr;
    logic [1:0]  a_ba, b_ba;

    sdram_boot_seq i_sdram_boot_seq (
        .clk(clk), .rst(rst),
        .cs_n(a_cmd[3]), .ras_n(a_cmd[2]), .cas_n(a_cmd[1]), .we_n(a_cmd[0]),
        .cke(a_cke), .dqm(a_dqm), .addr(a_addr), .ba(a_ba), .init_done(a_done)
    );

    sdram_boot_seq #(
        .CLK_PS(7500), .T_WAIT_NS(2000), .T_RP_NS(24), .T_RFC_NS(84), .T_MRD_NS(20),
        .REF_COUNT(9), .MODE_FIRST(1), .BURST_CODE(2), .INTERLEAVE(1), .CAS_LAT(2),
        .SINGLE_WRITE(1)
    ) i_sdram_boot_seq_alt (
        .clk(clk), .rst(rst),
        .cs_n(b_cmd[3]), .ras_n(b_cmd[2]), .cas_n(b_cmd[1]), .we_n(b_cmd[0]),
        .cke(b_cke), .dqm(b_dqm), .addr(b_addr), .ba(b_ba), .init_done(b_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: command expected at edge k after reset release
    function automatic logic [3:0] model_cmd(input int k, input int nw, input int rp,
            input int rf, input int mr, input int nr, input bit mf);
        int t;
        t = nw;
        if (k == t) return C_PRE;
        t += rp;
        if (mf) begin
            if (k == t) return C_MRS;
            t += mr;
        end
        for (int i = 0; i < nr; i++) begin
            if (k == t) return C_REF;
            t += rf;
        end
        if (!mf && k == t) return C_MRS;
        return C_NOP;
    endfunction

    function automatic int model_done(input int nw, input int rp, input int rf,
            input int mr, input int nr);
        return nw + rp + nr * rf + mr;
    endfunction

    int k = 0;
    int rst_edges = 0;
    always @(posedge clk) begin
        if (rst) begin
            k <= 0;
            rst_edges <= rst_edges + 1;
        end else begin
            k <= k + 1;
            rst_edges <= 0;
        end
    end

    logic [3:0] log_cmd [2][0:31];
    int         log_t   [2][0:31];
    int         log_n   [2];
    int         log_done[2];

    task automatic check_bus(input string who, input logic [3:0] cmd, input logic [11:0] addr,
            input logic [1:0] ba, input logic [7:0] dqm, input logic cke, input logic done,
            input int nw, input int rp, input int rf, input int mr, input int nr,
            input bit mf, input logic [11:0] mw);
        logic [3:0]  e;
        logic [11:0] ea;
        string       tag;
        bit          ed;
        e  = model_cmd(k, nw, rp, rf, mr, nr, mf);
        ed = (k >= model_done(nw, rp, rf, mr, nr));
        if (e == C_PRE)      begin tag = "R3"; ea = 12'h400; end
        else if (e == C_REF) begin tag = "R5"; ea = 12'h000; end
        else if (e == C_MRS) begin tag = "R4"; ea = mw;      end
        else begin tag = (k < nw) ? "R1" : (ed ? "R8" : "R7"); ea = 12'h000; end
        chk(cmd == e, tag, {who, " command"}, cmd, e);
        chk(addr == ea, tag, {who, " address"}, addr, ea);
        chk(ba == 2'b00, tag, {who, " bank"}, ba, 0);
        chk(cke == 1'b1, "R2", {who, " cke"}, cke, 1);
        chk(dqm == (ed ? 8'h00 : 8'hFF), "R2", {who, " dqm"}, dqm, ed ? 8'h00 : 8'hFF);
        chk(done == ed, "R8", {who, " init_done"}, done, ed);
    endtask

    task automatic check_reset_state(input string who, input logic [3:0] cmd,
            input logic [7:0] dqm, input logic cke, input logic done);
        chk(cmd == C_NOP, "R9", {who, " reset command"}, cmd, C_NOP);
        chk(dqm == 8'hFF, "R9", {who, " reset dqm"}, dqm, 8'hFF);
        chk(cke == 1'b1, "R9", {who, " reset cke"}, cke, 1);
        chk(done == 1'b0, "R9", {who, " reset init_done"}, done, 0);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            if (rst_edges >= 1) begin
                check_reset_state("A", a_cmd, a_dqm, a_cke, a_done);
                check_reset_state("B", b_cmd, b_dqm, b_cke, b_done);
            end
        end else if (k >= 1) begin
            check_bus("A", a_cmd, a_addr, a_ba, a_dqm, a_cke, a_done,
                      A_NW, A_RP, A_RF, A_MR, A_NR, A_MF, A_MW);
            check_bus("B", b_cmd, b_addr, b_ba, b_dqm, b_cke, b_done,
                      B_NW, B_RP, B_RF, B_MR, B_NR, B_MF, B_MW);
            if (a_cmd != C_NOP && log_n[0] < 32) begin
                log_cmd[0][log_n[0]] = a_cmd; log_t[0][log_n[0]] = k; log_n[0]++;
            end
            if (b_cmd != C_NOP && log_n[1] < 32) begin
                log_cmd[1][log_n[1]] = b_cmd; log_t[1][log_n[1]] = k; log_n[1]++;
            end
            if (a_done && log_done[0] < 0) log_done[0] = k;
            if (b_done && log_done[1] < 0) log_done[1] = k;
        end
    end

    function automatic int gap_after(input logic [3:0] c, input int rp, input int rf, input int mr);
        if (c == C_PRE) return rp;
        if (c == C_REF) return rf;
        return mr;
    endfunction

    // Order, refresh count and measured gaps from the observed command log
    task automatic check_seq(input int id, input string who, input int nw, input int rp,
            input int rf, input int mr, input int nr, input bit mf);
        int refs;
        logic [3:0] eo;
        refs = 0;
        chk(log_n[id] == nr + 2, "R6", {who, " command total"}, log_n[id], nr + 2);
        chk(log_t[id][0] == nw, "R1", {who, " first command edge"}, log_t[id][0], nw);
        for (int i = 0; i < log_n[id] && i < nr + 2; i++) begin
            if (i == 0) eo = C_PRE;
            else if (mf) eo = (i == 1) ? C_MRS : C_REF;
            else eo = (i == nr + 1) ? C_MRS : C_REF;
            chk(log_cmd[id][i] == eo, "R6", {who, " order"}, log_cmd[id][i], eo);
            if (log_cmd[id][i] == C_REF) refs++;
            if (i > 0)
                chk(log_t[id][i] - log_t[id][i-1] == gap_after(log_cmd[id][i-1], rp, rf, mr),
                    "R7", {who, " gap"}, log_t[id][i] - log_t[id][i-1],
                    gap_after(log_cmd[id][i-1], rp, rf, mr));
        end
        chk(refs == nr, "R5", {who, " refresh count"}, refs, nr);
        if (log_n[id] > 0)
            chk(log_done[id] - log_t[id][log_n[id]-1] ==
                    gap_after(log_cmd[id][log_n[id]-1], rp, rf, mr),
                "R7", {who, " final gap to done"}, log_done[id] - log_t[id][log_n[id]-1],
                gap_after(log_cmd[id][log_n[id]-1], rp, rf, mr));
    endtask

    task automatic run_once();
        int waited;
        log_n[0] = 0; log_n[1] = 0;
        log_done[0] = -1; log_done[1] = -1;
        @(negedge clk);
        rst = 1'b0;
        waited = 0;
        while (!(a_done && b_done) && waited < 60000) begin
            @(negedge clk);
            waited++;
        end
        if (!(a_done && b_done)) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: init_done not reached actual=%0d%0d expected=11",
                     a_done, b_done);
        end
        repeat (20) @(negedge clk);
        check_seq(0, "A", A_NW, A_RP, A_RF, A_MR, A_NR, A_MF);
        check_seq(1, "B", B_NW, B_RP, B_RF, B_MR, B_NR, B_MF);
    endtask

    initial begin
        log_n[0] = 0; log_n[1] = 0;
        log_done[0] = -1; log_done[1] = -1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        run_once();
        // R9: mid-life reset restarts the whole sequence
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        run_once();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule